// File: doc/BRIEF.md
# Panel Power Sequencer

This block switches a flat panel's supply rail and its backlight in a fixed, timed order. Software writes a keyed control word to ask for the panel on or off. The sequencer then walks through the phases and holds each one for a programmed number of 100 µs ticks. On the way up it raises the supply, waits for the panel to become ready, and only then lets the backlight come on. On the way down it drops the backlight first, then the supply, waits out the power-down time, and finally holds a power-cycle lockout. No new power-up can begin until that lockout ends.

All timing comes from one tick prescaler. Its divide count is a register field, so the same block works at any system clock rate. The register port has no buffering. A write is a single-cycle strobe that is always accepted and never stalls. A read is combinational from the read address.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset, both outputs are low and status reads 0. The delay registers read back their defaults: on-delays (2100<<16)|500, off-delays (5000<<16)|500, divisor (DEF_REF_DIV<<8)|7. Control reads 0.
- R2: A write to control (address 0) is accepted only when data bits 31:16 equal 0xABCD. Any other write leaves control and both outputs unchanged.
- R3: The tick period is max(divisor[31:8],1) clocks, and every phase timer restarts when its phase begins. If control bit 0 is set at clock edge W while idle, the supply rises after edge W+1. Status bit 31 (fully on) rises after edge W+2+U*D, where U is on-delays[28:16] and D is the tick period.
- R4: The backlight output is high only while the panel is fully on, control bit 2 is set, and B = on-delays[12:0] ticks have passed since fully on. It first rises after edge W+2+(U+B)*D.
- R5: If control bit 0 is cleared at edge W while fully on, the backlight falls after W+1. The supply falls after W+2+F*D, where F is off-delays[12:0].
- R6: Power-down lasts P = off-delays[28:16] ticks. The power-cycle lockout (status bit 27) follows and lasts C ticks, where C = (divisor[4:0]-1)*1000 when the field is above 1, and 0 otherwise. A pending on request starts power-up only one cycle after the lockout ends.
- R7: Status bits 29:28 read 01 while powering up, 10 from backlight-off through power-down, and 00 otherwise. Bit 31 is set only while fully on, bit 27 only in lockout, and bit 30 and bits 26:0 read 0.
- R8: Clearing control bit 0 during power-up aborts it. The supply falls after the next edge, and progress reads 10.
- R9: Control bit 3 forces the supply output high in every state, without changing the sequence status.
- R10: On-delays keeps port-select bits 31:30 and reads them back. Reserved bits of the on-delays, off-delays and divisor registers read 0. Writes to status (address 1) have no effect.
- R11: Clearing control bit 2 while fully on drops the backlight right after the write edge, and the supply stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Write word address: 0 control, 1 status, 2 on-delays, 3 off-delays, 4 divisor |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read word address, same map |
| rd_data | output | 32 | Combinational read data |
| panel_vdd | output | 1 | Panel supply enable |
| panel_bl | output | 1 | Backlight enable |

## Verification
The embedded properties assume that reset is asserted before the first edge and that the write address stays within the five defined words. The exact-cycle bench checks also assume that the delay and divisor fields hold still while a sequence runs. The stimulus respects this: it reprograms the delay and divisor registers only while the sequencer sits idle and off. Random phase lengths and tick periods are kept small enough that a full on/off/lockout cycle ends well inside the run limit.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int DLY_W = 13;
  localparam int CYC_W = 5;
  localparam int REF_W = 24;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_OND  = 3'd2;
  localparam logic [2:0] A_OFFD = 3'd3;
  localparam logic [2:0] A_DIV  = 3'd4;

  localparam logic [15:0] WR_KEY = 16'hABCD;

  typedef enum logic [2:0] {
    ST_OFF, ST_UP, ST_ON, ST_BLW, ST_DN, ST_CYC
  } seq_st_t;

  typedef struct packed {
    logic force_vdd;
    logic bl_en;
    logic pd_rst;
    logic on_req;
  } ctrl_t;
endpackage

// File: rtl/pps_regs.sv
module pps_regs
  import pps_pkg::*;
#(
  parameter int DEF_REF_DIV = 12500,
  parameter int DEF_UP      = 2100,
  parameter int DEF_BL      = 500,
  parameter int DEF_DN      = 5000,
  parameter int DEF_BLOFF   = 500,
  parameter int DEF_CYC     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [2:0]       rd_addr,
  input  logic [31:0]      status,
  output logic [31:0]      rd_data,
  output ctrl_t            ctrl,
  output logic [DLY_W-1:0] up_dly,
  output logic [DLY_W-1:0] bl_dly,
  output logic [DLY_W-1:0] dn_dly,
  output logic [DLY_W-1:0] bloff_dly,
  output logic [CYC_W-1:0] cyc_f,
  output logic [REF_W-1:0] ref_div
);
  logic [1:0] port_sel;
  logic       key_ok;

  assign key_ok = (wr_data[31:16] == WR_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      port_sel  <= '0;
      up_dly    <= DLY_W'(DEF_UP);
      bl_dly    <= DLY_W'(DEF_BL);
      dn_dly    <= DLY_W'(DEF_DN);
      bloff_dly <= DLY_W'(DEF_BLOFF);
      cyc_f     <= CYC_W'(DEF_CYC);
      ref_div   <= REF_W'(DEF_REF_DIV);
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: if (key_ok) ctrl <= ctrl_t'(wr_data[3:0]);
        A_OND: begin
          port_sel <= wr_data[31:30];
          up_dly   <= wr_data[16 +: DLY_W];
          bl_dly   <= wr_data[0 +: DLY_W];
        end
        A_OFFD: begin
          dn_dly    <= wr_data[16 +: DLY_W];
          bloff_dly <= wr_data[0 +: DLY_W];
        end
        A_DIV: begin
          ref_div <= wr_data[8 +: REF_W];
          cyc_f   <= wr_data[0 +: CYC_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[3:0] = ctrl;
      A_STAT: rd_data = status;
      A_OND: begin
        rd_data[31:30]       = port_sel;
        rd_data[16 +: DLY_W] = up_dly;
        rd_data[0 +: DLY_W]  = bl_dly;
      end
      A_OFFD: begin
        rd_data[16 +: DLY_W] = dn_dly;
        rd_data[0 +: DLY_W]  = bloff_dly;
      end
      A_DIV: begin
        rd_data[8 +: REF_W] = ref_div;
        rd_data[0 +: CYC_W] = cyc_f;
      end
      default: rd_data = '0;
    endcase
  end

  // R2
  key_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data[31:16] != WR_KEY) |=> $stable(ctrl));
endmodule

// File: rtl/pps_timer.sv
module pps_timer
  import pps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [REF_W-1:0] ref_div,
  input  logic [CNT_W-1:0] target,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [REF_W-1:0] pre;
  logic [REF_W-1:0] div_m1;
  logic [CNT_W-1:0] cnt;

  assign div_m1 = (ref_div == '0) ? '0 : ref_div - REF_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (restart) begin
      pre <= '0;
      cnt <= '0;
    end else if (pre >= div_m1) begin
      pre <= '0;
      if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end else begin
      pre <= pre + REF_W'(1);
    end
  end

  assign done = (cnt >= target);

  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int CYC_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_req,
  input  logic             bl_en,
  input  logic [DLY_W-1:0] up_dly,
  input  logic [DLY_W-1:0] bl_dly,
  input  logic [DLY_W-1:0] dn_dly,
  input  logic [DLY_W-1:0] bloff_dly,
  input  logic [CYC_W-1:0] cyc_f,
  input  logic             done,
  output logic             restart,
  output logic [CNT_W-1:0] target,
  output logic             vdd_seq,
  output logic             bl_o,
  output logic             fully_on,
  output logic [1:0]       prog,
  output logic             cyc_act
);
  seq_st_t st, nxt;
  logic [CNT_W-1:0] cyc_ticks;

  assign cyc_ticks = (cyc_f > CYC_W'(1))
                   ? CNT_W'(cyc_f - CYC_W'(1)) * CNT_W'(CYC_TICKS) : '0;

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF: if (on_req) nxt = ST_UP;
      ST_UP:  if (!on_req) nxt = ST_DN; else if (done) nxt = ST_ON;
      ST_ON:  if (!on_req) nxt = ST_BLW;
      ST_BLW: if (done) nxt = ST_DN;
      ST_DN:  if (done) nxt = ST_CYC;
      ST_CYC: if (done) nxt = ST_OFF;
      default: nxt = ST_OFF;
    endcase
  end

  always_comb begin
    case (st)
      ST_UP:   target = CNT_W'(up_dly);
      ST_ON:   target = CNT_W'(bl_dly);
      ST_BLW:  target = CNT_W'(bloff_dly);
      ST_DN:   target = CNT_W'(dn_dly);
      ST_CYC:  target = cyc_ticks;
      default: target = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= nxt;
  end

  assign restart  = (nxt != st);
  assign vdd_seq  = (st == ST_UP) || (st == ST_ON) || (st == ST_BLW);
  assign bl_o     = (st == ST_ON) && bl_en && done;
  assign fully_on = (st == ST_ON);
  assign cyc_act  = (st == ST_CYC);
  assign prog     = (st == ST_UP) ? 2'b01 :
                    ((st == ST_BLW) || (st == ST_DN)) ? 2'b10 : 2'b00;

  // R6
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CYC) |=> (st == ST_CYC || st == ST_OFF));

  // R5
  vdd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vdd_seq) |-> ($past(st) == ST_BLW || $past(st) == ST_UP));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UP && !on_req) |=> (st == ST_DN));
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int DEF_REF_DIV = 12500,
  parameter int CYC_TICKS   = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        panel_vdd,
  output logic        panel_bl
);
  localparam int CYC_MAX_T = ((1 << CYC_W) - 2) * CYC_TICKS;
  localparam int CNT_W     = $clog2(CYC_MAX_T + (1 << DLY_W) + 1);

  ctrl_t            ctrl;
  logic [DLY_W-1:0] up_dly, bl_dly, dn_dly, bloff_dly;
  logic [CYC_W-1:0] cyc_f;
  logic [REF_W-1:0] ref_div;
  logic [CNT_W-1:0] target;
  logic             restart, done, vdd_seq, bl_o, fully_on, cyc_act;
  logic [1:0]       prog;
  logic [31:0]      status;

  assign status = {fully_on, 1'b0, prog, cyc_act, 27'd0};

  pps_regs #(.DEF_REF_DIV(DEF_REF_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .status(status), .rd_data(rd_data),
    .ctrl(ctrl), .up_dly(up_dly), .bl_dly(bl_dly), .dn_dly(dn_dly),
    .bloff_dly(bloff_dly), .cyc_f(cyc_f), .ref_div(ref_div)
  );

  pps_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .ref_div(ref_div),
    .target(target), .done(done)
  );

  pps_fsm #(.CNT_W(CNT_W), .CYC_TICKS(CYC_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .on_req(ctrl.on_req), .bl_en(ctrl.bl_en),
    .up_dly(up_dly), .bl_dly(bl_dly), .dn_dly(dn_dly), .bloff_dly(bloff_dly),
    .cyc_f(cyc_f), .done(done), .restart(restart), .target(target),
    .vdd_seq(vdd_seq), .bl_o(bl_o), .fully_on(fully_on), .prog(prog),
    .cyc_act(cyc_act)
  );

  assign panel_vdd = vdd_seq | ctrl.force_vdd;
  assign panel_bl  = bl_o;

  // R4
  bl_needs_vdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    panel_bl |-> (panel_vdd && fully_on));

  // R7
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fully_on, prog != 2'b00, cyc_act}) && prog != 2'b11);
endmodule

// File: tb/sim_panel_pwr_seq.sv
module sim_panel_pwr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        panel_vdd, panel_bl;
  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  localparam logic [31:0] KEY = 32'hABCD_0000;

  always #4 clk = ~clk;

  panel_pwr_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .panel_vdd(panel_vdd), .panel_bl(panel_bl)
  );

  function automatic int cyc_ticks(input int f);
    return (f > 1) ? (f - 1) * 1000 : 0;
  endfunction

  function automatic int eff_div(input int r);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  function automatic bit cond(input int sel);
    case (sel)
      0: return panel_vdd;
      1: return !panel_vdd;
      2: return panel_bl;
      3: return !panel_bl;
      4: return rd_data[31];
      5: return rd_data[27];
      6: return !rd_data[27];
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_for(input int sel, output int n);
    rd_addr = 3'd1; #1;
    n = 0;
    while (!cond(sel) && n < 100000) begin
      @(negedge clk); #1;
      n++;
    end
    if (n >= 100000) begin
      errors++;
      $display("FAIL wait timeout sel=%0d actual=%0d expected=<100000", sel, n);
    end
  endtask

  // full up/down sequence with exact timing
  task automatic run_seq(input int up, input int bl, input int bo, input int pd,
                         input int cf, input int r);
    int d, t, n;
    logic [31:0] v;
    d = eff_div(r);
    wr(3'd4, (r << 8) | cf);
    wr(3'd2, (up << 16) | bl);
    wr(3'd3, (pd << 16) | bo);
    wr(3'd0, KEY | 32'h5);
    t = 0;
    wait_for(0, n); t += n; check("R3 supply rise", t, 1);
    rd(3'd1, v); if (up > 0) check("R7 progress up", v[29:28], 1);
    wait_for(4, n); t += n; check("R3 fully on", t, 2 + up * d);
    wait_for(2, n); t += n; check("R4 backlight rise", t, 2 + (up + bl) * d);
    wr(3'd0, KEY | 32'h4);
    t = 0;
    wait_for(3, n); t += n; check("R5 backlight fall", t, 1);
    rd(3'd1, v); check("R7 progress down", v[29:28], 2);
    wait_for(1, n); t += n; check("R5 supply fall", t, 2 + bo * d);
    wait_for(5, n); t += n; check("R6 lockout start", t, 3 + (bo + pd) * d);
    wait_for(6, n); t += n;
    check("R6 lockout end", t, 4 + (bo + pd + cyc_ticks(cf)) * d);
    rd(3'd1, v); check("R7 idle status", v, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int t, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 vdd", panel_vdd, 0);
    check("R1 bl", panel_bl, 0);
    rd(3'd1, v); check("R1 status", v, 0);
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd2, v); check("R1 on-delays", v, (2100 << 16) | 500);
    rd(3'd3, v); check("R1 off-delays", v, (5000 << 16) | 500);
    rd(3'd4, v); check("R1 divisor", v, (12500 << 8) | 7);

    // R2 unkeyed write ignored
    wr(3'd0, 32'h0000_000D);
    rd(3'd0, v); check("R2 ctrl unkeyed", v, 0);
    repeat (5) @(negedge clk);
    check("R2 vdd stays off", panel_vdd, 0);

    // R10 readback masks, port select, status write ignored
    wr(3'd2, 32'hBFFF_FFFF);
    rd(3'd2, v); check("R10 on-delays readback", v, 32'h9FFF_1FFF);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R10 off-delays readback", v, 32'h1FFF_1FFF);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); check("R10 divisor readback", v, 32'hFFFF_FF1F);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R10 status write ignored", v, 0);

    // directed sequence
    run_seq(3, 2, 1, 2, 2, 2);

    // R6 re-request during lockout
    wr(3'd4, (1 << 8) | 2);
    wr(3'd2, (2 << 16) | 1);
    wr(3'd3, (3 << 16) | 2);
    wr(3'd0, KEY | 32'h1);
    wait_for(4, n);
    wr(3'd0, KEY | 32'h0);
    t = 0;
    wr(3'd0, KEY | 32'h1); t += 2;
    wait_for(1, n); t += n; check("R6 supply fall", t, 4);
    wait_for(0, n); t += n; check("R6 repower after lockout", t, 5 + 2 + 3 + 1000);

    // R8 abort during power-up
    wr(3'd2, (20 << 16) | 1);
    wr(3'd0, KEY | 32'h1);
    wait_for(0, n);
    wr(3'd0, KEY | 32'h0);
    t = 0;
    wait_for(1, n); t += n; check("R8 abort supply fall", t, 1);
    rd(3'd1, v); check("R8 abort progress", v[29:28], 2);
    wait_for(6, n);
    repeat (3) @(negedge clk);
    wait_for(6, n);
    @(negedge clk);
    wr(3'd4, (1 << 8) | 0);
    repeat (1010) @(negedge clk);

    // R9 override
    wr(3'd0, KEY | 32'h8);
    check("R9 forced supply", panel_vdd, 1);
    rd(3'd1, v); check("R9 status idle", v, 0);
    wr(3'd0, KEY | 32'h0);
    check("R9 release", panel_vdd, 0);

    // R11 backlight disable while on
    wr(3'd2, (1 << 16) | 0);
    wr(3'd0, KEY | 32'h5);
    wait_for(2, n);
    wr(3'd0, KEY | 32'h1);
    check("R11 backlight off", panel_bl, 0);
    check("R11 supply kept", panel_vdd, 1);
    wr(3'd0, KEY | 32'h0);
    wait_for(6, n);
    wait_for(5, n);
    wait_for(6, n);
    @(negedge clk);

    // constrained random sequences
    for (int i = 0; i < 6; i++) begin
      run_seq($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 7), $urandom_range(0, 2), $urandom_range(0, 3));
    end

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule